// File: doc/BRIEF.md
# Program/Erase Sequence Error Checker

This block sits beside the command logic of a non-volatile memory controller. It judges every data write and every erase start against the mode bits the control register holds: standard program, fast program, page erase and mass erase. For each such attempt it decides whether the sequence is illegal or whether the target is protected. An attempt that passes both tests is forwarded to the array as a one-cycle go pulse. An attempt that fails either test sets a sticky flag and is blocked.

Other error sources elsewhere in the controller report through set pulses. These cover program, size, alignment, data-miss and fast-program errors. All seven sticky flags feed an operation-error flag and an interrupt line, gated by an interrupt enable. Software clears each flag by writing 1 to its bit. A clear that arrives during a run of back-to-back data writes is ignored.

Top module: `pe_err_check`

## Requirements
- R1: After a synchronous active-low reset, all flags, `op_err_o`, `irq_o` and `array_go_o` are 0.
- R2: A data write (`wr_strobe`) with both `mode_prog` and `mode_fast` clear sets the sequence flag (`flags_o[5]`) one cycle later.
- R3: A data write with `mode_prog` or `mode_fast` set while `mode_page_erase` or `mode_mass_erase` is also set sets the sequence flag one cycle later.
- R4: The sequence flag is set one cycle after a start (`start_strobe`) in any of these cases:
  - mass erase is requested while `mode_prog`, `mode_fast` or `mode_page_erase` is set;
  - page erase is requested without mass erase while a program bit is set;
  - neither erase bit is set.
- R5: A write or start attempted while any of the seven flags is already set sets the sequence flag one cycle later.
- R6: The protection flag (`flags_o[6]`) is set one cycle after a write or start with `prot_hit` high. It is also set one cycle after a start with `mode_mass_erase` set while `prot_pages` is non-zero.
- R7: With `rdp_level` = 1, a write or start while `dbg_or_alt_boot` is high sets the protection flag. At level 0 the same stimulus has no effect on the flags.
- R8: With `rdp_level` of 2 or 3, an `opt_modify_req` pulse sets the protection flag one cycle later. At levels 0 and 1 it has no effect.
- R9: `op_err_o` is set one cycle after a cycle in which any flag is set and `err_irq_en` is high. It is sticky, and `irq_o` equals it. With `err_irq_en` low, `op_err_o` is not set.
- R10: Writing 1 to `flag_clr[i]` clears flag i (i = 0..6), and `flag_clr[7]` clears `op_err_o`. A clear is ignored in the cycle of a data write and in the `BURST_GAP` (4) cycles that follow it. A set wins over a clear.
- R11: A write or start that raises neither the sequence nor the protection condition produces `array_go_o` high for exactly the next cycle. Otherwise `array_go_o` stays low.
- R12: `ext_err_set[k]` sets flag k one cycle later. The bits are: 0 program, 1 size, 2 alignment, 3 data miss, 4 fast program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_prog | input | 1 | Standard program mode bit |
| mode_fast | input | 1 | Fast program mode bit |
| mode_page_erase | input | 1 | Page erase mode bit |
| mode_mass_erase | input | 1 | Mass erase mode bit |
| wr_strobe | input | 1 | Data write to the array |
| start_strobe | input | 1 | Erase start request |
| prot_hit | input | 1 | Target lies in a write- or code-protected area |
| prot_pages | input | PAGE_CNT_W (8) | Number of protected pages |
| dbg_or_alt_boot | input | 1 | Debugger attached or boot from SRAM/system memory |
| rdp_level | input | 2 | Read-protection level 0, 1, 2 (3 treated as 2) |
| opt_modify_req | input | 1 | Request to modify option bytes |
| err_irq_en | input | 1 | Error interrupt enable |
| ext_err_set | input | 5 | Set pulses for program, size, alignment, miss, fast errors |
| flag_clr | input | 8 | Write-1-to-clear strobes, bit 7 for the operation error |
| flags_o | output | 7 | Sticky flags: 0..4 external, 5 sequence, 6 protection |
| op_err_o | output | 1 | Sticky operation-error flag |
| irq_o | output | 1 | Error interrupt |
| array_go_o | output | 1 | Forwarded operation pulse to the array |

## Verification
The assertions check several rules on every cycle. A write with no program bit always yields the sequence flag. A protected-area hit always yields the protection flag. A blocked attempt never produces a go pulse. Flags never drop during a write burst, and the operation error rises only after a flag and the enable were both present.

Only the bench's scenarios can show the other behaviours:
- the exact mode combinations that each rule accepts or rejects;
- the stale-flag interaction;
- the read-protection levels that must leave the flags alone;
- the precise length of the clear-blocking window.

The bench follows each of these with a cycle-accurate reference model.

// File: rtl/pe_err_pkg.sv
// Package: shared flag indices and the mode-bit bundle for the
// program/erase error checker. Assumes seven sticky flags.
package pe_err_pkg;
    localparam int unsigned NUM_EXT   = 5;
    localparam int unsigned FLG_SEQ   = 5;
    localparam int unsigned FLG_PROT  = 6;
    localparam int unsigned NUM_FLAGS = 7;

    typedef struct packed {
        logic prog;
        logic fast;
        logic page;
        logic mass;
    } mode_t;
endpackage

// File: rtl/pe_seq_rule.sv
// Sequence rule: combinational test of one write or start against the
// mode bits and the stale-flag state. Assumes at most one strobe matters
// per cycle; both strobes are judged if both arrive.
module pe_seq_rule
    import pe_err_pkg::*;
(
    input  mode_t mode,
    input  logic  wr,
    input  logic  start,
    input  logic  stale,
    output logic  viol
);
    logic any_prog;
    logic wr_bad;
    logic start_bad;

    // Purpose: classify the write and the start separately.
    always_comb begin
        any_prog  = mode.prog | mode.fast;
        wr_bad    = 1'b0;
        start_bad = 1'b0;
        if (wr) begin
            if (!any_prog)
                wr_bad = 1'b1;
            else if (mode.page || mode.mass)
                wr_bad = 1'b1;
        end
        if (start) begin
            unique case ({mode.mass, mode.page})
                2'b10, 2'b11: start_bad = any_prog | mode.page;
                2'b01:        start_bad = any_prog;
                default:      start_bad = 1'b1;
            endcase
        end
    end

    assign viol = wr_bad | start_bad | ((wr | start) & stale);
endmodule

// File: rtl/pe_prot_rule.sv
// Protection rule: combinational test of region hits, protected page
// count for mass erase, and read-protection level context.
// Assumes level code 3 behaves as level 2.
module pe_prot_rule #(
    parameter int unsigned PAGE_CNT_W = 8
) (
    input  logic                  wr,
    input  logic                  start,
    input  logic                  mass,
    input  logic                  hit,
    input  logic [PAGE_CNT_W-1:0] pages,
    input  logic                  dbg_alt,
    input  logic [1:0]            rdp,
    input  logic                  opt_req,
    output logic                  viol
);
    logic attempt;
    logic lvl1;
    logic lvl2;

    // Purpose: decode level and combine the protection causes.
    always_comb begin
        attempt = wr | start;
        lvl1    = (rdp == 2'd1);
        lvl2    = rdp[1];
        viol    = 1'b0;
        if (attempt && hit)                   viol = 1'b1;
        if (start && mass && (|pages))        viol = 1'b1;
        if (attempt && lvl1 && dbg_alt)       viol = 1'b1;
        if (opt_req && lvl2)                  viol = 1'b1;
    end
endmodule

// File: rtl/pe_flag_bank.sv
// Flag bank: sticky write-1-to-clear flags, burst window that blocks
// clears, and the operation-error flag under the interrupt enable.
// Assumes set wins over clear in the same cycle.
module pe_flag_bank #(
    parameter int unsigned NFLAG     = 7,
    parameter int unsigned BURST_GAP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_vec,
    input  logic [NFLAG:0]   clr_vec,
    input  logic             wr,
    input  logic             irq_en,
    output logic [NFLAG-1:0] flags_q,
    output logic             op_err_q
);
    localparam int unsigned GW = $clog2(BURST_GAP + 1);

    logic [GW-1:0] gap_q;
    logic          burst;

    assign burst = wr | (gap_q != '0);

    // Purpose: count the idle cycles after the latest data write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_q <= '0;
        else if (wr)
            gap_q <= GW'(BURST_GAP);
        else if (gap_q != '0)
            gap_q <= gap_q - 1'b1;
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        // Purpose: one sticky flag with blockable clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags_q[i] <= 1'b0;
            else if (set_vec[i])
                flags_q[i] <= 1'b1;
            else if (clr_vec[i] && !burst)
                flags_q[i] <= 1'b0;
        end
    end

    // Purpose: operation-error flag from any flag under the enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            op_err_q <= 1'b0;
        else if ((|flags_q) && irq_en)
            op_err_q <= 1'b1;
        else if (clr_vec[NFLAG] && !burst)
            op_err_q <= 1'b0;
    end

    a_r10_no_drop_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        burst |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
    a_r9_op_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(op_err_q) |-> $past((|flags_q) && irq_en));
endmodule

// File: rtl/pe_err_check.sv
// Top: program/erase sequence error checker. Judges writes and starts,
// sets sticky flags, forwards legal operations as a one-cycle pulse.
// Assumes strobes are single-cycle and synchronous to clk.
module pe_err_check
    import pe_err_pkg::*;
#(
    parameter int unsigned PAGE_CNT_W = 8,
    parameter int unsigned BURST_GAP  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_prog,
    input  logic                  mode_fast,
    input  logic                  mode_page_erase,
    input  logic                  mode_mass_erase,
    input  logic                  wr_strobe,
    input  logic                  start_strobe,
    input  logic                  prot_hit,
    input  logic [PAGE_CNT_W-1:0] prot_pages,
    input  logic                  dbg_or_alt_boot,
    input  logic [1:0]            rdp_level,
    input  logic                  opt_modify_req,
    input  logic                  err_irq_en,
    input  logic [NUM_EXT-1:0]    ext_err_set,
    input  logic [NUM_FLAGS:0]    flag_clr,
    output logic [NUM_FLAGS-1:0]  flags_o,
    output logic                  op_err_o,
    output logic                  irq_o,
    output logic                  array_go_o
);
    mode_t                mode;
    logic                 seq_viol;
    logic                 prot_viol;
    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] flags_q;
    logic                 op_err_q;
    logic                 go_q;

    assign mode = '{prog: mode_prog, fast: mode_fast,
                    page: mode_page_erase, mass: mode_mass_erase};

    pe_seq_rule i_seq (
        .mode  (mode),
        .wr    (wr_strobe),
        .start (start_strobe),
        .stale (|flags_q),
        .viol  (seq_viol)
    );

    pe_prot_rule #(.PAGE_CNT_W(PAGE_CNT_W)) i_prot (
        .wr      (wr_strobe),
        .start   (start_strobe),
        .mass    (mode_mass_erase),
        .hit     (prot_hit),
        .pages   (prot_pages),
        .dbg_alt (dbg_or_alt_boot),
        .rdp     (rdp_level),
        .opt_req (opt_modify_req),
        .viol    (prot_viol)
    );

    assign set_vec = {prot_viol, seq_viol, ext_err_set};

    pe_flag_bank #(.NFLAG(NUM_FLAGS), .BURST_GAP(BURST_GAP)) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_vec  (flag_clr),
        .wr       (wr_strobe),
        .irq_en   (err_irq_en),
        .flags_q  (flags_q),
        .op_err_q (op_err_q)
    );

    // Purpose: forward a legal operation to the array for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            go_q <= 1'b0;
        else
            go_q <= (wr_strobe | start_strobe) & ~seq_viol & ~prot_viol;
    end

    assign flags_o    = flags_q;
    assign op_err_o   = op_err_q;
    assign irq_o      = op_err_q;
    assign array_go_o = go_q;

    a_r2_write_no_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && !mode_prog && !mode_fast) |=> flags_o[FLG_SEQ]);
    a_r6_region_hit: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_strobe || start_strobe) && prot_hit) |=> flags_o[FLG_PROT]);
    a_r11_blocked_no_go: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_viol || prot_viol) |=> !array_go_o);
    a_r11_go_single: assert property (@(posedge clk) disable iff (!rst_n)
        (array_go_o && !$past(wr_strobe || start_strobe)) |-> 1'b0);
endmodule

// File: tb/test_pe_err_check.sv
module test_pe_err_check;
    localparam int GAP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_p = 0, m_f = 0, m_pe = 0, m_me = 0;
    logic wr = 0, st = 0, hit = 0, dbg = 0, opt = 0, en = 0;
    logic [7:0] pages = 0;
    logic [1:0] rdp = 0;
    logic [4:0] ext = 0;
    logic [7:0] clr = 0;
    logic [6:0] flags;
    logic op_err, irq, go;

    pe_err_check i_pe_err_check (
        .clk(clk), .rst_n(rst_n), .mode_prog(m_p), .mode_fast(m_f),
        .mode_page_erase(m_pe), .mode_mass_erase(m_me), .wr_strobe(wr),
        .start_strobe(st), .prot_hit(hit), .prot_pages(pages),
        .dbg_or_alt_boot(dbg), .rdp_level(rdp), .opt_modify_req(opt),
        .err_irq_en(en), .ext_err_set(ext), .flag_clr(clr),
        .flags_o(flags), .op_err_o(op_err), .irq_o(irq), .array_go_o(go));

    always #5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    bit cmp_en = 0;
    string cur_req = "R1";

    // Reference model state
    logic [6:0] e_flags;
    logic e_op, e_go;
    int e_gap;

    always @(posedge clk) begin
        if (!rst_n) begin
            e_flags <= 0; e_op <= 0; e_go <= 0; e_gap <= 0;
        end else begin
            bit sq, pr, att, blk;
            logic [6:0] nf;
            sq = 0; pr = 0;
            att = wr || st;
            if (wr && !(m_p || m_f)) sq = 1;
            if (wr && (m_p || m_f) && (m_pe || m_me)) sq = 1;
            if (st) begin
                if (m_me) sq = sq | m_p | m_f | m_pe;
                else if (m_pe) sq = sq | m_p | m_f;
                else sq = 1;
            end
            if (att && e_flags != 0) sq = 1;
            if (att && hit) pr = 1;
            if (st && m_me && pages != 0) pr = 1;
            if (att && rdp == 1 && dbg) pr = 1;
            if (opt && rdp >= 2) pr = 1;
            blk = wr || (e_gap > 0);
            nf = e_flags;
            if (!blk) nf = nf & ~clr[6:0];
            nf = nf | {pr, sq, ext};
            e_flags <= nf;
            if (e_flags != 0 && en) e_op <= 1;
            else if (clr[7] && !blk) e_op <= 0;
            e_go <= att && !sq && !pr;
            if (wr) e_gap <= GAP;
            else if (e_gap > 0) e_gap <= e_gap - 1;
        end
    end

    task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            chk("flags", {1'b0, flags}, {1'b0, e_flags});
            chk("op_err", {7'd0, op_err}, {7'd0, e_op});
            chk("irq", {7'd0, irq}, {7'd0, e_op});
            chk("go", {7'd0, go}, {7'd0, e_go});
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(logic p, logic f, logic pe, logic me);
        m_p = p; m_f = f; m_pe = pe; m_me = me;
    endtask

    task automatic pulse_wr();
        @(negedge clk); wr = 1; @(negedge clk); wr = 0;
    endtask

    task automatic pulse_st();
        @(negedge clk); st = 1; @(negedge clk); st = 0;
    endtask

    task automatic clear_all();
        idle(GAP + 2);
        clr = 8'hFF; @(negedge clk); clr = 0;
        idle(2);
    endtask

    task automatic expect_now(string what, logic [6:0] exp_flags, logic exp_go);
        chk(what, {1'b0, flags}, {1'b0, exp_flags});
        chk({what, " go"}, {7'd0, go}, {7'd0, exp_go});
    endtask

    initial begin
        idle(3);
        rst_n = 1;
        @(negedge clk);
        cur_req = "R1";
        chk("reset flags", {1'b0, flags}, 8'd0);
        chk("reset irq", {7'd0, irq}, 8'd0);
        chk("reset go", {7'd0, go}, 8'd0);
        cmp_en = 1;

        cur_req = "R11";
        set_mode(1, 0, 0, 0);
        @(negedge clk); wr = 1; @(negedge clk); wr = 0;
        expect_now("R11 legal write", 7'd0, 1);
        @(negedge clk);
        chk("R11 single pulse", {7'd0, go}, 8'd0);
        set_mode(0, 0, 1, 0); pulse_st();
        set_mode(0, 0, 0, 1); pulse_st();
        set_mode(0, 1, 0, 0); pulse_wr();
        clear_all();

        cur_req = "R2";
        set_mode(0, 0, 0, 0);
        @(negedge clk); wr = 1; @(negedge clk); wr = 0;
        expect_now("R2 write no mode", 7'h20, 0);
        clear_all();

        cur_req = "R3";
        set_mode(1, 0, 1, 0); pulse_wr(); clear_all();
        set_mode(0, 1, 0, 1); pulse_wr(); clear_all();

        cur_req = "R4";
        set_mode(1, 0, 0, 1); pulse_st(); clear_all();
        set_mode(0, 0, 1, 1); pulse_st(); clear_all();
        set_mode(0, 1, 1, 0); pulse_st(); clear_all();
        set_mode(0, 0, 0, 0);
        @(negedge clk); st = 1; @(negedge clk); st = 0;
        expect_now("R4 start no erase", 7'h20, 0);
        clear_all();

        cur_req = "R12";
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); ext = 5'(1 << k); @(negedge clk); ext = 0;
            chk("R12 ext bit", {1'b0, flags}, 8'(1 << k));
            clear_all();
        end

        cur_req = "R5";
        @(negedge clk); ext = 5'h04; @(negedge clk); ext = 0;
        set_mode(1, 0, 0, 0);
        @(negedge clk); wr = 1; @(negedge clk); wr = 0;
        expect_now("R5 stale", 7'h24, 0);
        clear_all();

        cur_req = "R6";
        set_mode(1, 0, 0, 0); hit = 1;
        @(negedge clk); wr = 1; @(negedge clk); wr = 0; hit = 0;
        expect_now("R6 hit", 7'h40, 0);
        clear_all();
        set_mode(0, 0, 0, 1); pages = 8'd1;
        pulse_st(); pages = 0; clear_all();
        pages = 8'd3; set_mode(0, 0, 1, 0); pulse_st(); pages = 0;
        clear_all();

        cur_req = "R7";
        set_mode(1, 0, 0, 0); dbg = 1; rdp = 2'd1;
        @(negedge clk); wr = 1; @(negedge clk); wr = 0;
        expect_now("R7 level1 dbg", 7'h40, 0);
        clear_all();
        rdp = 2'd0;
        @(negedge clk); wr = 1; @(negedge clk); wr = 0;
        expect_now("R7 level0 dbg", 7'h00, 1);
        dbg = 0; clear_all();

        cur_req = "R8";
        for (int l = 0; l < 4; l++) begin
            rdp = 2'(l);
            @(negedge clk); opt = 1; @(negedge clk); opt = 0;
            chk("R8 opt req", {1'b0, flags}, (l >= 2) ? 8'h40 : 8'h00);
            clear_all();
        end
        rdp = 0;

        cur_req = "R9";
        en = 1;
        @(negedge clk); ext = 5'h01; @(negedge clk); ext = 0;
        @(negedge clk);
        chk("R9 op_err set", {7'd0, op_err}, 8'd1);
        chk("R9 irq", {7'd0, irq}, 8'd1);
        en = 0; clear_all();
        chk("R9 cleared", {7'd0, op_err}, 8'd0);
        @(negedge clk); ext = 5'h02; @(negedge clk); ext = 0;
        idle(2);
        chk("R9 disabled", {7'd0, op_err}, 8'd0);
        clear_all();

        cur_req = "R10";
        @(negedge clk); ext = 5'h08; @(negedge clk); ext = 0;
        set_mode(1, 0, 0, 0);
        @(negedge clk); wr = 1; @(negedge clk); wr = 0;
        for (int c = 0; c < GAP; c++) begin
            clr = 8'hFF; @(negedge clk); clr = 0;
            chk("R10 clear blocked", {1'b0, flags}, 8'h28);
        end
        clr = 8'hFF; @(negedge clk); clr = 0;
        chk("R10 clear works", {1'b0, flags}, 8'h00);
        @(negedge clk); ext = 5'h10; clr = 8'h10; @(negedge clk); ext = 0; clr = 0;
        chk("R10 set wins", {1'b0, flags}, 8'h10);
        clear_all();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule